// File: doc/BRIEF.md
# Upper-Memory Shadow and ROM Decoder

This block sits on the memory side of a 486-class notebook controller. For each CPU memory cycle it picks the target of the access among the 640 KB to 1 MB region and main memory below it. The three targets are DRAM (used as shadow copy or as plain memory), the BIOS ROM chip select, and the AT expansion bus. The choice depends on a small bank of byte-wide configuration registers. Software reaches that bank through an index port and a data port.

The C, D and E ranges are each cut into four 16 KB segments. Every segment has two controls of its own: a bit that steers it to ROM or to the bus, and a shadow enable. Write protection is set per range, not per segment. A global copy mode makes reads fetch from ROM or the bus while writes land in DRAM. With it, firmware can copy an image onto its own addresses and then switch the shadow on. The F range has one read-source bit and one write-target bit.

The decision is registered. One cycle after a request the block presents one-hot target selects and a write-inhibit flag.

Top module: `umem_decoder`

## Requirements
- R1: After reset every register at indices 30h–3Bh reads 00h, except 32h, which reads 80h. A read of the F range (F0000h–FFFFFh) therefore goes to ROM.
- R2: A write with `cfg_port`=0 loads the index. A write with `cfg_port`=1 loads the indexed register. A read with `cfg_port`=1 returns the indexed register on `cfg_rdata` one cycle later. An index outside 30h–3Bh reads 00h, and writes to it change no register.
- R3: A request for segment numbers below 28h (addresses below A0000h) selects DRAM. A request for A0000h–BFFFFh always selects the AT bus.
- R4: C-range segments C0000h, C4000h, C8000h and CC000h are steered by bits 1, 2, 3 and 4 of register 38h. When the segment is unshadowed and copy mode is off, 1 selects ROM and 0 selects the bus.
- R5: D-range segments D0000h–DC000h are steered by bits 4–7 of register 37h, lowest address first. E-range segments E0000h–EC000h are steered by bits 0–3 of register 31h. In both cases 1 selects ROM.
- R6: The shadow enables are bits 0–3 of 36h for the C range, bits 0–3 of 33h for the D range and bits 4–7 of 33h for the E range, lowest address first. Outside copy mode, reads and writes of a shadowed segment go to DRAM.
- R7: When bit 6 of 36h is set, every C/D/E segment sends reads to ROM or the bus by its steering bit and sends writes to DRAM, whatever its shadow enable. These writes are never inhibited.
- R8: The write-protect bits are 36h bit 5 for the C range, 32h bit 4 for D and 32h bit 3 for E. A write to a shadowed, protected segment outside copy mode selects DRAM and raises `wr_inhibit`. Reads, and writes to unshadowed segments, never raise it.
- R9: For the F range, a read selects ROM when 32h bit 7 is 1 and DRAM when it is 0. A write selects ROM when 36h bit 7 is 1 and DRAM when it is 0.
- R10: Outputs appear on the cycle after the request. Exactly one select is high while `dec_valid` is high, and all are low otherwise. A register write takes effect for a request issued on any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_port | input | 1 | 0 = index port, 1 = data port |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, valid the cycle after `cfg_rd` |
| mem_valid | input | 1 | Memory request present |
| mem_seg | input | 6 | Address bits 19:14 of the request (16 KB segment number) |
| mem_we | input | 1 | 1 = write cycle, 0 = read cycle |
| dec_valid | output | 1 | Decision below belongs to the previous cycle's request |
| sel_dram | output | 1 | Target is DRAM |
| sel_rom | output | 1 | Target is the BIOS ROM chip select |
| sel_bus | output | 1 | Target is the AT expansion bus |
| wr_inhibit | output | 1 | The DRAM write must be dropped (protected shadow) |

## Verification
The steering checks use a walking single bit in each range's steering field and sweep all four segments of that range. This catches any segment wired to a neighbour's bit. The shadow checks use all-ones and partial enable patterns to show that a shadow enable overrides steering only for its own segment. The copy-mode sweep runs reads and writes over one segment with shadow and protect both on and off, which separates copy mode from the shadow path. The protect checks pair writes with reads and shadowed segments with unshadowed ones, so a global inhibit fails them. The F-range checks flip the read and write bits independently.

// File: rtl/umd_pkg.sv
package umd_pkg;
  // index of the first register and the size of the bank
  localparam logic [7:0] REG_BASE  = 8'h30;
  localparam int         REG_COUNT = 12;

  // offsets inside the bank for the registers the decoder uses
  localparam int OFF_ESTEER = 1;  // 31h: E-range steering, low nibble
  localparam int OFF_PROT   = 2;  // 32h: F read source, D/E protect
  localparam int OFF_SHDE   = 3;  // 33h: D/E shadow enables
  localparam int OFF_CCTL   = 6;  // 36h: F write, copy, C protect, C shadow
  localparam int OFF_DSTEER = 7;  // 37h: D-range steering, high nibble
  localparam int OFF_CSTEER = 8;  // 38h: C-range steering, bits 4:1

  typedef struct packed {
    logic [3:0] c_steer;
    logic [3:0] d_steer;
    logic [3:0] e_steer;
    logic [3:0] c_shadow;
    logic [3:0] d_shadow;
    logic [3:0] e_shadow;
    logic       c_wp;
    logic       d_wp;
    logic       e_wp;
    logic       copy_mode;
    logic       f_rd_rom;
    logic       f_wr_rom;
  } cfg_view_t;

  function automatic logic [7:0] reg_reset(input int off);
    return (off == OFF_PROT) ? 8'h80 : 8'h00;
  endfunction
endpackage

// File: rtl/umd_cfg_regs.sv
module umd_cfg_regs
  import umd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic              cfg_port,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output cfg_view_t         view
);
  localparam int OFF_W = $clog2(REG_COUNT);

  logic [DATA_W-1:0] regs [REG_COUNT];
  logic [DATA_W-1:0] idx;
  logic [DATA_W-1:0] diff;
  logic [OFF_W-1:0]  off;
  logic              in_range;

  assign diff     = idx - DATA_W'(REG_BASE);
  assign off      = diff[OFF_W-1:0];
  assign in_range = (idx >= DATA_W'(REG_BASE)) &&
                    (idx < DATA_W'(REG_BASE) + DATA_W'(REG_COUNT));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      cfg_rdata <= '0;
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= DATA_W'(reg_reset(i));
    end else begin
      if (cfg_wr) begin
        if (!cfg_port)     idx       <= cfg_wdata;
        else if (in_range) regs[off] <= cfg_wdata;
      end
      if (cfg_rd)
        cfg_rdata <= !cfg_port ? idx : (in_range ? regs[off] : '0);
    end
  end

  always_comb begin
    view.e_steer   = regs[OFF_ESTEER][3:0];
    view.f_rd_rom  = regs[OFF_PROT][7];
    view.d_wp      = regs[OFF_PROT][4];
    view.e_wp      = regs[OFF_PROT][3];
    view.d_shadow  = regs[OFF_SHDE][3:0];
    view.e_shadow  = regs[OFF_SHDE][7:4];
    view.f_wr_rom  = regs[OFF_CCTL][7];
    view.copy_mode = regs[OFF_CCTL][6];
    view.c_wp      = regs[OFF_CCTL][5];
    view.c_shadow  = regs[OFF_CCTL][3:0];
    view.d_steer   = regs[OFF_DSTEER][7:4];
    view.c_steer   = regs[OFF_CSTEER][4:1];
  end

  // R1
  boot_from_rom_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (view.f_rd_rom && !view.copy_mode));

  // R2
  oob_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_port && !in_range) |=> $stable(view));
endmodule

// File: rtl/umd_seg_lookup.sv
module umd_seg_lookup
  import umd_pkg::*;
#(
  parameter int SEG_W   = 6,
  parameter int NREGION = 3
) (
  input  logic [SEG_W-1:0] seg,
  input  logic             we,
  input  cfg_view_t        view,
  output logic [2:0]       sel,     // [0] DRAM, [1] ROM, [2] AT bus
  output logic             inhibit
);
  localparam logic [3:0] NIB_VIDEO = 4'hA;
  localparam logic [3:0] NIB_C     = 4'hC;
  localparam logic [3:0] NIB_F     = 4'hF;

  logic [3:0] nib;
  logic [1:0] sub;
  logic [3:0] steer_f  [NREGION];
  logic [3:0] shadow_f [NREGION];
  logic       wp_f     [NREGION];
  logic [NREGION-1:0] hit, st_r, sh_r, wp_r;
  logic st, sh, wp, in_cde;

  assign nib = seg[SEG_W-1:SEG_W-4];
  assign sub = seg[1:0];

  assign steer_f[0]  = view.c_steer;
  assign steer_f[1]  = view.d_steer;
  assign steer_f[2]  = view.e_steer;
  assign shadow_f[0] = view.c_shadow;
  assign shadow_f[1] = view.d_shadow;
  assign shadow_f[2] = view.e_shadow;
  assign wp_f[0]     = view.c_wp;
  assign wp_f[1]     = view.d_wp;
  assign wp_f[2]     = view.e_wp;

  // one slice per 64 KB region; only the hit region contributes
  for (genvar r = 0; r < NREGION; r++) begin : g_region
    assign hit[r]  = (nib == NIB_C + 4'(r));
    assign st_r[r] = hit[r] & steer_f[r][sub];
    assign sh_r[r] = hit[r] & shadow_f[r][sub];
    assign wp_r[r] = hit[r] & wp_f[r];
  end

  assign in_cde = |hit;
  assign st     = |st_r;
  assign sh     = |sh_r;
  assign wp     = |wp_r;

  always_comb begin
    sel     = 3'b001;
    inhibit = 1'b0;
    if (nib == NIB_F) begin
      sel = (we ? view.f_wr_rom : view.f_rd_rom) ? 3'b010 : 3'b001;
    end else if (in_cde) begin
      if (view.copy_mode) begin
        sel = we ? 3'b001 : (st ? 3'b010 : 3'b100);
      end else if (sh) begin
        sel     = 3'b001;
        inhibit = we & wp;
      end else begin
        sel = st ? 3'b010 : 3'b100;
      end
    end else if (nib >= NIB_VIDEO) begin
      sel = 3'b100;
    end
  end
endmodule

// File: rtl/umem_decoder.sv
module umem_decoder
  import umd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic              cfg_port,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              mem_valid,
  input  logic [SEG_W-1:0]  mem_seg,
  input  logic              mem_we,
  output logic              dec_valid,
  output logic              sel_dram,
  output logic              sel_rom,
  output logic              sel_bus,
  output logic              wr_inhibit
);
  localparam logic [SEG_W-1:0] SEG_VIDEO = SEG_W'(6'h28);
  localparam logic [SEG_W-1:0] SEG_C     = SEG_W'(6'h30);
  localparam logic [SEG_W-1:0] SEG_F     = SEG_W'(6'h3C);

  cfg_view_t  view;
  logic [2:0] nxt_sel;
  logic       nxt_inh;

  umd_cfg_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_port(cfg_port), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .view(view)
  );

  umd_seg_lookup #(.SEG_W(SEG_W)) u_lookup (
    .seg(mem_seg), .we(mem_we), .view(view),
    .sel(nxt_sel), .inhibit(nxt_inh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      sel_dram   <= 1'b0;
      sel_rom    <= 1'b0;
      sel_bus    <= 1'b0;
      wr_inhibit <= 1'b0;
    end else begin
      dec_valid  <= mem_valid;
      sel_dram   <= mem_valid & nxt_sel[0];
      sel_rom    <= mem_valid & nxt_sel[1];
      sel_bus    <= mem_valid & nxt_sel[2];
      wr_inhibit <= mem_valid & nxt_inh;
    end
  end

  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> ($countones({sel_dram, sel_rom, sel_bus}) == 1));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !(sel_dram || sel_rom || sel_bus || wr_inhibit));

  // R8
  inhibit_dram_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_we) |=> !wr_inhibit);

  // R3
  low_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_seg < SEG_VIDEO) |=> (sel_dram && !wr_inhibit));

  // R7
  copy_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_we && view.copy_mode && mem_seg >= SEG_C && mem_seg < SEG_F)
      |=> (sel_dram && !wr_inhibit));
endmodule

// File: tb/tb_umem_decoder.sv
module tb_umem_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_port = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       mem_valid = 1'b0, mem_we = 1'b0;
  logic [5:0] mem_seg = '0;
  logic       dec_valid, sel_dram, sel_rom, sel_bus, wr_inhibit;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] m [12];             // bench copy of what it wrote
  logic [3:0] exp_q [$];          // {inh, bus, rom, dram}
  string      tag_q [$];
  logic [19:0] adr_q [$];

  always #4 clk = ~clk;           // 125 MHz

  umem_decoder dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_port(cfg_port), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_valid(mem_valid), .mem_seg(mem_seg), .mem_we(mem_we),
    .dec_valid(dec_valid), .sel_dram(sel_dram), .sel_rom(sel_rom),
    .sel_bus(sel_bus), .wr_inhibit(wr_inhibit)
  );

  // expected target from the requirement text
  function automatic logic [3:0] model(input logic [19:0] a, input logic we);
    logic [3:0] nib; int s; logic st, sh, wp;
    nib = a[19:16]; s = int'(a[15:14]);
    if (nib < 4'hA) return 4'b0001;                         // R3
    if (nib < 4'hC) return 4'b0100;                         // R3
    if (nib == 4'hF)                                        // R9
      return (we ? m[6][7] : m[2][7]) ? 4'b0010 : 4'b0001;
    case (nib)
      4'hC: begin st = m[8][s+1]; sh = m[6][s];   wp = m[6][5]; end // R4 R6 R8
      4'hD: begin st = m[7][s+4]; sh = m[3][s];   wp = m[2][4]; end // R5 R6 R8
      default: begin st = m[1][s]; sh = m[3][s+4]; wp = m[2][3]; end
    endcase
    if (m[6][6]) return we ? 4'b0001 : (st ? 4'b0010 : 4'b0100);  // R7
    if (sh) return {we & wp, 3'b001};
    return st ? 4'b0010 : 4'b0100;
  endfunction

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
    @(negedge clk); mem_valid = 1'b0;
    cfg_wr = 1'b1; cfg_port = 1'b0; cfg_wdata = idx;
    @(negedge clk); cfg_port = 1'b1; cfg_wdata = val;
    @(negedge clk); cfg_wr = 1'b0;
    if (idx >= 8'h30 && idx <= 8'h3B) m[idx - 8'h30] = val;
  endtask

  task automatic cfg_check(input logic [7:0] idx, input logic [7:0] expv, input string tag);
    @(negedge clk); mem_valid = 1'b0;
    cfg_wr = 1'b1; cfg_port = 1'b0; cfg_wdata = idx;
    @(negedge clk); cfg_wr = 1'b0; cfg_rd = 1'b1; cfg_port = 1'b1;
    @(negedge clk); cfg_rd = 1'b0;
    checks++;
    if (cfg_rdata !== expv) begin
      errors++;
      $display("FAIL %s: reg %h read %h expected %h", tag, idx, cfg_rdata, expv);
    end
  endtask

  // driver: present one request and push its expected decision
  task automatic issue(input logic [19:0] a, input logic we, input string tag);
    @(negedge clk);
    mem_valid = 1'b1; mem_seg = a[19:14]; mem_we = we;
    exp_q.push_back(model(a, we)); tag_q.push_back(tag); adr_q.push_back(a);
  endtask

  task automatic idle();
    @(negedge clk); mem_valid = 1'b0;
  endtask

  task automatic sweep(input logic [19:0] base, input logic we, input string tag);
    for (int k = 0; k < 4; k++) issue(base + 20'(k) * 20'h4000, we, tag);
  endtask

  // monitor: compare each decision against the scoreboard head
  always @(negedge clk) begin
    if (!rst) begin
      if (dec_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10: decision with no request, got %b expected none",
                   {wr_inhibit, sel_bus, sel_rom, sel_dram});
        end else begin
          logic [3:0] e; string t; logic [19:0] a;
          e = exp_q.pop_front(); t = tag_q.pop_front(); a = adr_q.pop_front();
          if ({wr_inhibit, sel_bus, sel_rom, sel_dram} !== e) begin
            errors++;
            $display("FAIL %s: addr %h got %b expected %b", t, a,
                     {wr_inhibit, sel_bus, sel_rom, sel_dram}, e);
          end
        end
      end else if ({wr_inhibit, sel_bus, sel_rom, sel_dram} !== 4'b0000) begin
        checks++; errors++;
        $display("FAIL R10: idle outputs %b expected 0000",
                 {wr_inhibit, sel_bus, sel_rom, sel_dram});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 12; i++) m[i] = (i == 2) ? 8'h80 : 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    for (int i = 0; i < 12; i++)
      cfg_check(8'h30 + 8'(i), (i == 2) ? 8'h80 : 8'h00, "R1");
    issue(20'hF0000, 1'b0, "R1 F read from ROM");
    issue(20'hF8000, 1'b1, "R9 F write to DRAM");
    idle();

    // R2: bank access and out-of-range indices
    cfg_write(8'h3A, 8'h5C);
    cfg_check(8'h3A, 8'h5C, "R2");
    cfg_write(8'h3C, 8'hFF);
    cfg_check(8'h3C, 8'h00, "R2");
    cfg_write(8'h2F, 8'hFF);
    cfg_check(8'h2F, 8'h00, "R2");
    cfg_check(8'h30, 8'h00, "R2");

    // R3: low memory and video window
    issue(20'h00000, 1'b0, "R3"); issue(20'h9C000, 1'b1, "R3");
    issue(20'hA0000, 1'b0, "R3"); issue(20'hBC000, 1'b1, "R3");
    idle();

    // R4: walking steering bit across the C range
    for (int k = 0; k < 4; k++) begin
      cfg_write(8'h38, 8'(1 << (k + 1)));
      sweep(20'hC0000, 1'b0, "R4"); sweep(20'hC0000, 1'b1, "R4");
      idle();
    end
    cfg_write(8'h38, 8'h00);

    // R5: D and E ranges
    for (int k = 0; k < 4; k++) begin
      cfg_write(8'h37, 8'(16 << k));
      cfg_write(8'h31, 8'(1 << k));
      sweep(20'hD0000, 1'b0, "R5"); sweep(20'hE0000, 1'b0, "R5");
      idle();
    end

    // R6: shadow enables, full and partial
    cfg_write(8'h31, 8'h0F); cfg_write(8'h37, 8'hF0); cfg_write(8'h38, 8'h1E);
    cfg_write(8'h36, 8'h0F); cfg_write(8'h33, 8'hFF);
    sweep(20'hC0000, 1'b0, "R6"); sweep(20'hD0000, 1'b1, "R6");
    sweep(20'hE0000, 1'b0, "R6"); idle();
    cfg_write(8'h36, 8'h05); cfg_write(8'h33, 8'h6A);
    sweep(20'hC0000, 1'b0, "R6"); sweep(20'hD0000, 1'b0, "R6");
    sweep(20'hE0000, 1'b1, "R6"); idle();

    // R7: copy-mode sweep of C8000h, shadow off then on with protect
    cfg_write(8'h36, 8'h40); cfg_write(8'h38, 8'h08);
    for (int k = 0; k < 8; k++) begin
      issue(20'hC8000 + 20'(k * 16'h0800), 1'b0, "R7 copy read");
      issue(20'hC8000 + 20'(k * 16'h0800), 1'b1, "R7 copy write");
    end
    issue(20'hCC000, 1'b0, "R7 copy read bus");
    idle();
    cfg_write(8'h36, 8'h6F); cfg_write(8'h32, 8'h98);
    sweep(20'hC0000, 1'b1, "R7"); sweep(20'hD0000, 1'b1, "R7");
    sweep(20'hC0000, 1'b0, "R7"); idle();

    // R8: write protect per range
    cfg_write(8'h36, 8'h23); cfg_write(8'h33, 8'h31); cfg_write(8'h32, 8'h90);
    sweep(20'hC0000, 1'b1, "R8"); sweep(20'hC0000, 1'b0, "R8");
    sweep(20'hD0000, 1'b1, "R8"); sweep(20'hE0000, 1'b1, "R8");
    idle();
    cfg_write(8'h32, 8'h08);
    sweep(20'hE0000, 1'b1, "R8"); sweep(20'hD0000, 1'b1, "R8");
    idle();

    // R9: F range read and write controls
    cfg_write(8'h32, 8'h00);
    issue(20'hF0000, 1'b0, "R9"); issue(20'hFC000, 1'b1, "R9");
    idle();
    cfg_write(8'h36, 8'h80);
    issue(20'hF4000, 1'b0, "R9"); issue(20'hF4000, 1'b1, "R9");
    idle();

    // R10: a register write is seen by the very next request
    cfg_write(8'h38, 8'h02);
    issue(20'hC0000, 1'b0, "R10");
    idle();
    cfg_write(8'h38, 8'h00);
    issue(20'hC0000, 1'b0, "R10");
    idle(); idle(); idle();

    done = 1'b1;
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: %0d decisions missing, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule